// File: doc/BRIEF.md
# Issue-Stage Arbiter with Replay Priority

This block makes the final per-cycle decision on which operations leave an issue queue for the execution pipes. It has two sources. The first is a replay FIFO that holds memory operations that were retried and must be sent again. The second is a set of P scheduled candidates, one per output port, each marked as a load, a store or some other kind. Replayed entries are handled first, oldest first, and each one takes one of the P issue slots. The scheduled candidates then fill the slots that are left, in ascending port order.

Three resources are shared between the two sources: the P issue slots, a fixed number of load pipes and a fixed number of store pipes. In addition, a load cannot go out during a cycle in which the data cache signals that it will write a refill tag on the next cycle. When a scheduled candidate cannot issue, the block raises its reject line. The surrounding queue uses that line to clear the candidate's scheduled state and put it back into the ready queue, so the candidate is not lost.

The block reports how many operations issued in the cycle, and a strobe that is high when that number is nonzero, for use by a distribution statistic. The replay FIFO raises a full flag so that the retry path stops pushing while no entry is free.

Top module: `issue_arbiter`

## Requirements
- R1: Replay slots are taken from the FIFO head in age order: slot k carries the k-th oldest entry, the issued slots always form a contiguous run starting at slot 0, and at most P entries replay in one cycle.
- R2: Replay stops at the first load (kind code 1) it reaches while the refill-tag-write input is high, or while all LD_PIPES load pipes are already used in this cycle. No younger entry replays in that cycle, whatever its kind.
- R3: Replay stops at the first store (kind code 2) it reaches once all ST_PIPES store pipes are used in this cycle. No younger entry replays in that cycle.
- R4: A scheduled candidate on port i is rejected whenever i plus the number of replayed entries in the same cycle is P or more.
- R5: Load and store pipe usage is counted across replay first and then across the ports in ascending index. A valid candidate of kind 1 is rejected once LD_PIPES loads have issued. A valid candidate of kind 2 is rejected once ST_PIPES stores have issued. Kinds 0 and 3 count against neither cap, and a rejected candidate uses up no pipe.
- R6: While refill-tag-write is high, no scheduled load issues, even when load pipes are free.
- R7: Every valid scheduled candidate raises exactly one of its issue line and its reject line. An invalid candidate raises neither.
- R8: The issued count equals the number of replayed entries plus the number of issued ports. The statistic strobe is high exactly when that count is nonzero.
- R9: A push into the replay FIFO is accepted only when the FIFO is not full. A push while full is ignored and leaves the stored entries and their order unchanged. The full flag is high exactly when RQ_DEPTH entries are held, and the count output tracks pushes minus replays.
- R10: While reset is asserted the replay FIFO is empty, not full, and nothing issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rq_push_i | input | 1 | Push a retried operation into the replay FIFO |
| rq_push_kind_i | input | 2 | Kind of the pushed entry (0 other, 1 load, 2 store, 3 other) |
| rq_push_tag_i | input | TAG_W | Tag of the pushed entry |
| rq_full_o | output | 1 | Replay FIFO holds RQ_DEPTH entries |
| rq_count_o | output | $clog2(RQ_DEPTH+1) | Replay FIFO occupancy |
| refill_tag_wr_i | input | 1 | Data cache writes a refill tag next cycle; loads blocked |
| sch_valid_i | input | P | Scheduled candidate present, one bit per port |
| sch_kind_i | input | 2*P | Kind of each port's candidate, port i at bits 2i+1:2i |
| rp_issue_o | output | P | Replay slot k issues the k-th oldest FIFO entry |
| rp_kind_o | output | 2*P | Kind of each issued replay slot, zero when not issued |
| rp_tag_o | output | TAG_W*P | Tag of each issued replay slot, zero when not issued |
| port_issue_o | output | P | Scheduled candidate on port i issues |
| port_reject_o | output | P | Scheduled candidate on port i goes back to the ready queue |
| issued_cnt_o | output | $clog2(P+1) | Total operations issued this cycle |
| issued_stat_o | output | 1 | Strobe for the issue-count statistic, high when the count is nonzero |

## Verification
The assertions rely on two properties of the inputs. Pushes arrive only through the push strobe, with the kind and tag held stable alongside it. The count check also relies on reset having emptied the FIFO before the first push. Beyond that, the assertions accept any kind code, including the unused code 3, and any mix of valid bits. The stimulus changes inputs only on the falling edge. It drives every combination of port validity, port kind and refill state with an empty FIFO. It then fills the FIFO to overflow while loads are blocked, and finally runs a long pseudo-random mix that keeps the FIFO partly occupied, so that replay and ports compete for slots and pipes.

// File: rtl/issue_arb_pkg.sv
package issue_arb_pkg;

  typedef enum logic [1:0] {
    OPK_OTHER = 2'd0,
    OPK_LOAD  = 2'd1,
    OPK_STORE = 2'd2,
    OPK_RSVD  = 2'd3
  } op_kind_e;

  function automatic logic kind_is_load(input logic [1:0] k);
    return k == OPK_LOAD;
  endfunction

  function automatic logic kind_is_store(input logic [1:0] k);
    return k == OPK_STORE;
  endfunction

endpackage

// File: rtl/issue_replay_fifo.sv
module issue_replay_fifo #(
  parameter int DEPTH   = 8,
  parameter int TAG_W   = 8,
  parameter int POP_MAX = 4,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int POP_W  = $clog2(POP_MAX + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            push_i,
  input  logic [1:0]                      push_kind_i,
  input  logic [TAG_W-1:0]                push_tag_i,
  input  logic [POP_W-1:0]                pop_cnt_i,
  output logic [POP_MAX-1:0]              head_valid_o,
  output logic [POP_MAX-1:0][1:0]         head_kind_o,
  output logic [POP_MAX-1:0][TAG_W-1:0]   head_tag_o,
  output logic                            full_o,
  output logic [CNT_W-1:0]                count_o
);

  logic [1:0]       kind_mem [DEPTH];
  logic [TAG_W-1:0] tag_mem  [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             push_ok;

  function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    return PTR_W'(s % DEPTH);
  endfunction

  assign full_o  = (int'(count_q) == DEPTH);
  assign count_o = count_q;
  assign push_ok = push_i && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      rd_ptr_q <= ptr_add(rd_ptr_q, int'(pop_cnt_i));
      if (push_ok) wr_ptr_q <= ptr_add(wr_ptr_q, 1);
      count_q  <= CNT_W'(int'(count_q) + (push_ok ? 1 : 0) - int'(pop_cnt_i));
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) begin
      kind_mem[wr_ptr_q] <= push_kind_i;
      tag_mem[wr_ptr_q]  <= push_tag_i;
    end
  end

  for (genvar k = 0; k < POP_MAX; k++) begin : g_head
    logic [PTR_W-1:0] idx;
    assign idx             = ptr_add(rd_ptr_q, k);
    assign head_valid_o[k] = (k < int'(count_q));
    assign head_kind_o[k]  = kind_mem[idx];
    assign head_tag_o[k]   = tag_mem[idx];
  end

endmodule

// File: rtl/issue_replay_sel.sv
module issue_replay_sel
  import issue_arb_pkg::*;
#(
  parameter int P        = 4,
  parameter int LD_PIPES = 2,
  parameter int ST_PIPES = 1,
  localparam int CW      = $clog2(P + 1)
) (
  input  logic [P-1:0]      head_valid_i,
  input  logic [P-1:0][1:0] head_kind_i,
  input  logic              refill_i,
  output logic [P-1:0]      go_o,
  output logic [CW-1:0]     rp_cnt_o,
  output logic [CW-1:0]     ld_used_o,
  output logic [CW-1:0]     st_used_o
);

  always_comb begin
    int   n_ld, n_st, n_rp;
    logic run;
    n_ld = 0;
    n_st = 0;
    n_rp = 0;
    run  = 1'b1;
    go_o = '0;
    for (int k = 0; k < P; k++) begin
      if (run && head_valid_i[k]) begin
        if (kind_is_load(head_kind_i[k])) begin
          // first blocked load halts the whole replay walk
          if (refill_i || n_ld >= LD_PIPES) run = 1'b0;
          else begin
            go_o[k] = 1'b1;
            n_ld++;
            n_rp++;
          end
        end else if (kind_is_store(head_kind_i[k])) begin
          if (n_st >= ST_PIPES) run = 1'b0;
          else begin
            go_o[k] = 1'b1;
            n_st++;
            n_rp++;
          end
        end else begin
          go_o[k] = 1'b1;
          n_rp++;
        end
      end else begin
        run = 1'b0;
      end
    end
    rp_cnt_o  = CW'(n_rp);
    ld_used_o = CW'(n_ld);
    st_used_o = CW'(n_st);
  end

endmodule

// File: rtl/issue_port_sel.sv
module issue_port_sel
  import issue_arb_pkg::*;
#(
  parameter int P        = 4,
  parameter int LD_PIPES = 2,
  parameter int ST_PIPES = 1,
  localparam int CW      = $clog2(P + 1)
) (
  input  logic [P-1:0]      valid_i,
  input  logic [P-1:0][1:0] kind_i,
  input  logic              refill_i,
  input  logic [CW-1:0]     rp_cnt_i,
  input  logic [CW-1:0]     ld_base_i,
  input  logic [CW-1:0]     st_base_i,
  output logic [P-1:0]      accept_o,
  output logic [P-1:0]      reject_o
);

  always_comb begin
    int   n_ld, n_st;
    logic is_ld, is_st, deny;
    n_ld     = int'(ld_base_i);
    n_st     = int'(st_base_i);
    accept_o = '0;
    reject_o = '0;
    for (int i = 0; i < P; i++) begin
      is_ld = kind_is_load(kind_i[i]);
      is_st = kind_is_store(kind_i[i]);
      deny  = (i + int'(rp_cnt_i) >= P)
            || (is_ld && (refill_i || n_ld >= LD_PIPES))
            || (is_st && n_st >= ST_PIPES);
      if (valid_i[i]) begin
        if (deny) reject_o[i] = 1'b1;
        else begin
          accept_o[i] = 1'b1;
          if (is_ld) n_ld++;
          if (is_st) n_st++;
        end
      end
    end
  end

endmodule

// File: rtl/issue_arbiter.sv
module issue_arbiter
  import issue_arb_pkg::*;
#(
  parameter int P         = 4,
  parameter int LD_PIPES  = 2,
  parameter int ST_PIPES  = 1,
  parameter int RQ_DEPTH  = 8,
  parameter int TAG_W     = 8,
  localparam int CNT_W    = $clog2(RQ_DEPTH + 1),
  localparam int ISS_W    = $clog2(P + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rq_push_i,
  input  logic [1:0]           rq_push_kind_i,
  input  logic [TAG_W-1:0]     rq_push_tag_i,
  output logic                 rq_full_o,
  output logic [CNT_W-1:0]     rq_count_o,
  input  logic                 refill_tag_wr_i,
  input  logic [P-1:0]         sch_valid_i,
  input  logic [2*P-1:0]       sch_kind_i,
  output logic [P-1:0]         rp_issue_o,
  output logic [2*P-1:0]       rp_kind_o,
  output logic [TAG_W*P-1:0]   rp_tag_o,
  output logic [P-1:0]         port_issue_o,
  output logic [P-1:0]         port_reject_o,
  output logic [ISS_W-1:0]     issued_cnt_o,
  output logic                 issued_stat_o
);

  logic [P-1:0]            head_valid;
  logic [P-1:0][1:0]       head_kind;
  logic [P-1:0][TAG_W-1:0] head_tag;
  logic [P-1:0][1:0]       sch_kind;
  logic [P-1:0]            rp_go;
  logic [ISS_W-1:0]        rp_cnt, ld_used, st_used;

  assign sch_kind = sch_kind_i;

  issue_replay_fifo #(
    .DEPTH   (RQ_DEPTH),
    .TAG_W   (TAG_W),
    .POP_MAX (P)
  ) u_fifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (rq_push_i),
    .push_kind_i  (rq_push_kind_i),
    .push_tag_i   (rq_push_tag_i),
    .pop_cnt_i    (rp_cnt),
    .head_valid_o (head_valid),
    .head_kind_o  (head_kind),
    .head_tag_o   (head_tag),
    .full_o       (rq_full_o),
    .count_o      (rq_count_o)
  );

  issue_replay_sel #(
    .P        (P),
    .LD_PIPES (LD_PIPES),
    .ST_PIPES (ST_PIPES)
  ) u_rsel (
    .head_valid_i (head_valid),
    .head_kind_i  (head_kind),
    .refill_i     (refill_tag_wr_i),
    .go_o         (rp_go),
    .rp_cnt_o     (rp_cnt),
    .ld_used_o    (ld_used),
    .st_used_o    (st_used)
  );

  issue_port_sel #(
    .P        (P),
    .LD_PIPES (LD_PIPES),
    .ST_PIPES (ST_PIPES)
  ) u_psel (
    .valid_i   (sch_valid_i),
    .kind_i    (sch_kind),
    .refill_i  (refill_tag_wr_i),
    .rp_cnt_i  (rp_cnt),
    .ld_base_i (ld_used),
    .st_base_i (st_used),
    .accept_o  (port_issue_o),
    .reject_o  (port_reject_o)
  );

  assign rp_issue_o = rp_go;

  for (genvar k = 0; k < P; k++) begin : g_slot
    assign rp_kind_o[2*k +: 2]       = rp_go[k] ? head_kind[k] : 2'b00;
    assign rp_tag_o[TAG_W*k +: TAG_W] = rp_go[k] ? head_tag[k] : '0;
  end

  always_comb begin
    int n;
    n = int'(rp_cnt);
    for (int i = 0; i < P; i++) n += int'(port_issue_o[i]);
    issued_cnt_o  = ISS_W'(n);
    issued_stat_o = (n != 0);
  end

endmodule

// File: rtl/issue_arb_chk.sv
module issue_arb_chk
  import issue_arb_pkg::*;
#(
  parameter int P        = 4,
  parameter int LD_PIPES = 2,
  parameter int ST_PIPES = 1,
  parameter int RQ_DEPTH = 8,
  parameter int TAG_W    = 8,
  parameter int CNT_W    = 4,
  parameter int ISS_W    = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rq_push_i,
  input logic               rq_full_o,
  input logic [CNT_W-1:0]   rq_count_o,
  input logic               refill_tag_wr_i,
  input logic [P-1:0]       sch_valid_i,
  input logic [2*P-1:0]     sch_kind_i,
  input logic [P-1:0]       rp_issue_o,
  input logic [2*P-1:0]     rp_kind_o,
  input logic [P-1:0]       port_issue_o,
  input logic [P-1:0]       port_reject_o
);

  logic [P-1:0] p_ld, p_st, r_ld, r_st;
  int ld_total, st_total;

  always_comb begin
    for (int i = 0; i < P; i++) begin
      p_ld[i] = port_issue_o[i] && kind_is_load(sch_kind_i[2*i +: 2]);
      p_st[i] = port_issue_o[i] && kind_is_store(sch_kind_i[2*i +: 2]);
      r_ld[i] = rp_issue_o[i] && kind_is_load(rp_kind_o[2*i +: 2]);
      r_st[i] = rp_issue_o[i] && kind_is_store(rp_kind_o[2*i +: 2]);
    end
    ld_total = $countones(p_ld) + $countones(r_ld);
    st_total = $countones(p_st) + $countones(r_st);
  end

  // R1
  rp_prefix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rp_issue_o + P'(1)) & rp_issue_o) == '0);

  // R4
  for (genvar i = 0; i < P; i++) begin : g_slot_chk
    slot_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_issue_o[i] |-> (i + $countones(rp_issue_o) < P));
  end

  // R5
  ld_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_total <= LD_PIPES);

  // R5
  st_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_total <= ST_PIPES);

  // R6
  refill_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_tag_wr_i |-> ld_total == 0);

  // R7
  issue_reject_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_issue_o & port_reject_o) == '0);

  // R7
  issue_reject_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_issue_o | port_reject_o) == sch_valid_i);

  // R9
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rq_full_o && rq_push_i && rp_issue_o == '0) |=> $stable(rq_count_o));

  // R9
  count_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rq_count_o) == int'($past(rq_count_o)) + int'($past(rq_push_i && !rq_full_o))
                        - $countones($past(rp_issue_o)));

endmodule

bind issue_arbiter issue_arb_chk #(
  .P        (P),
  .LD_PIPES (LD_PIPES),
  .ST_PIPES (ST_PIPES),
  .RQ_DEPTH (RQ_DEPTH),
  .TAG_W    (TAG_W),
  .CNT_W    (CNT_W),
  .ISS_W    (ISS_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .rq_push_i       (rq_push_i),
  .rq_full_o       (rq_full_o),
  .rq_count_o      (rq_count_o),
  .refill_tag_wr_i (refill_tag_wr_i),
  .sch_valid_i     (sch_valid_i),
  .sch_kind_i      (sch_kind_i),
  .rp_issue_o      (rp_issue_o),
  .rp_kind_o       (rp_kind_o),
  .port_issue_o    (port_issue_o),
  .port_reject_o   (port_reject_o)
);

// File: tb/tb_issue_arbiter.sv
`timescale 1ns/1ps
module tb_issue_arbiter;
  localparam int P = 4, LDP = 2, STP = 1, DEPTH = 8, TW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_ni;
  logic          rq_push;
  logic [1:0]    rq_push_kind;
  logic [TW-1:0] rq_push_tag;
  logic          refill;
  logic [P-1:0]  sch_valid;
  logic [2*P-1:0] sch_kind;
  logic          rq_full;
  logic [3:0]    rq_count;
  logic [P-1:0]  rp_issue, port_issue, port_reject;
  logic [2*P-1:0] rp_kind;
  logic [TW*P-1:0] rp_tag;
  logic [2:0]    issued_cnt;
  logic          issued_stat;

  issue_arbiter dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rq_push_i(rq_push), .rq_push_kind_i(rq_push_kind), .rq_push_tag_i(rq_push_tag),
    .rq_full_o(rq_full), .rq_count_o(rq_count), .refill_tag_wr_i(refill),
    .sch_valid_i(sch_valid), .sch_kind_i(sch_kind),
    .rp_issue_o(rp_issue), .rp_kind_o(rp_kind), .rp_tag_o(rp_tag),
    .port_issue_o(port_issue), .port_reject_o(port_reject),
    .issued_cnt_o(issued_cnt), .issued_stat_o(issued_stat)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int mq_kind [DEPTH];
  int mq_tag  [DEPTH];
  int mq_n = 0;
  int exp_rp, exp_acc, exp_rej, exp_r, exp_cnt;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_eval();
    int ld, st, kd;
    bit run;
    ld = 0; st = 0; exp_r = 0; exp_rp = 0; exp_acc = 0; exp_rej = 0; run = 1;
    for (int k = 0; k < P; k++) begin
      if (run && k < mq_n) begin
        kd = mq_kind[k];
        if (kd == 1) begin
          if (refill || ld >= LDP) run = 0;
          else begin exp_rp |= (1 << k); exp_r++; ld++; end
        end else if (kd == 2) begin
          if (st >= STP) run = 0;
          else begin exp_rp |= (1 << k); exp_r++; st++; end
        end else begin
          exp_rp |= (1 << k); exp_r++;
        end
      end else run = 0;
    end
    exp_cnt = exp_r;
    for (int i = 0; i < P; i++) begin
      kd = int'(sch_kind[2*i +: 2]);
      if (sch_valid[i]) begin
        if ((i + exp_r >= P) || (kd == 1 && (refill || ld >= LDP)) || (kd == 2 && st >= STP))
          exp_rej |= (1 << i);
        else begin
          exp_acc |= (1 << i); exp_cnt++;
          if (kd == 1) ld++;
          if (kd == 2) st++;
        end
      end
    end
  endtask

  task automatic step();
    bit push_ok;
    #1;
    model_eval();
    chk(int'(rp_issue) == exp_rp, "R1 R2 R3 replay slots", int'(rp_issue), exp_rp);
    for (int k = 0; k < P; k++)
      if (exp_rp[k]) chk(int'(rp_tag[TW*k +: TW]) == mq_tag[k], "R1 replay tag order",
                         int'(rp_tag[TW*k +: TW]), mq_tag[k]);
    chk(int'(port_issue) == exp_acc, "R4 R5 R6 port issue", int'(port_issue), exp_acc);
    chk(int'(port_reject) == exp_rej, "R7 port reject", int'(port_reject), exp_rej);
    chk(int'(issued_cnt) == exp_cnt, "R8 issued count", int'(issued_cnt), exp_cnt);
    chk(issued_stat == (exp_cnt != 0), "R8 stat strobe", int'(issued_stat), int'(exp_cnt != 0));
    chk(int'(rq_count) == mq_n, "R9 occupancy", int'(rq_count), mq_n);
    chk(rq_full == (mq_n == DEPTH), "R9 full flag", int'(rq_full), int'(mq_n == DEPTH));
    push_ok = rq_push && (mq_n < DEPTH);
    for (int j = 0; j + exp_r < mq_n; j++) begin
      mq_kind[j] = mq_kind[j + exp_r];
      mq_tag[j]  = mq_tag[j + exp_r];
    end
    mq_n -= exp_r;
    if (push_ok) begin
      mq_kind[mq_n] = int'(rq_push_kind);
      mq_tag[mq_n]  = int'(rq_push_tag);
      mq_n++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; rq_push = 1'b0; rq_push_kind = '0; rq_push_tag = '0;
    refill = 1'b0; sch_valid = '0; sch_kind = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(rq_count == 0, "R10 reset count", int'(rq_count), 0);
    chk(rq_full == 1'b0, "R10 reset full", int'(rq_full), 0);
    chk(rp_issue == '0, "R10 reset replay", int'(rp_issue), 0);
    chk(issued_cnt == 0, "R10 reset issued", int'(issued_cnt), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // exhaustive port sweep, empty replay FIFO
    for (int rf = 0; rf < 2; rf++)
      for (int v = 0; v < 16; v++)
        for (int kc = 0; kc < 256; kc++) begin
          refill = rf[0]; sch_valid = 4'(v); sch_kind = 8'(kc);
          step();
        end

    // overflow while loads are blocked (R9), then drain (R2)
    refill = 1'b1; sch_valid = '0;
    for (int n = 0; n < 11; n++) begin
      rq_push = 1'b1; rq_push_kind = 2'd1; rq_push_tag = 8'(100 + n);
      step();
    end
    rq_push = 1'b0;
    #1;
    chk(rq_count == 4'(DEPTH), "R9 overflow ignored", int'(rq_count), DEPTH);
    refill = 1'b0; sch_valid = 4'hF; sch_kind = 8'b00_10_01_00;
    for (int n = 0; n < 6; n++) step();

    // mixed pseudo-random traffic
    for (int it = 0; it < 15000; it++) begin
      rq_push      = ($urandom % 4) != 0;
      rq_push_kind = 2'($urandom);
      rq_push_tag  = 8'($urandom);
      refill       = ($urandom % 4) == 0;
      sch_valid    = 4'($urandom);
      sch_kind     = 8'($urandom);
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule